// File: doc/BRIEF.md
# Asynchronous Host Bus to Wishbone Master Bridge

This block lets an external processor reach an on-chip Wishbone bus through its plain asynchronous memory interface. The host supplies a 12-bit word address, a shared 16-bit bidirectional data bus, an active-low chip select and separate active-low read (output-enable) and write strobes. The bridge brings the control strobes and the address/data payload into the bus clock domain through a two-stage synchronizer. It then runs exactly one Wishbone master cycle per chip-select assertion, with strobe and cycle raised together and the write flag set from the write strobe.

Read data returned with the slave acknowledge is captured in a holding register. That register is driven back onto the host data bus whenever chip select and output enable are both low. At all other times the data pins are left high-impedance so the host can drive them. Address decoding to individual slaves is left to a separate interconnect placed behind the bridge.

Top module: `hostbus_wb_bridge`

## Requirements
- R1: While reset is held low, `wb_stb_o`, `wb_cyc_o` and `wb_we_o` are 0 and `wb_adr_o` is 0.
- R2: `wb_adr_o` equals the host address shifted left by one, with bit 0 fixed at 0, so host address 0xFFF becomes 0x1FFE.
- R3: Chip select and a strobe are applied between two rising edges. `wb_stb_o` is still 0 after the second following rising edge and is 1 after the third.
- R4: `wb_cyc_o` always equals `wb_stb_o`.
- R5: A cycle started with the write strobe (`host_we_n` = 0) has `wb_we_o` = 1 and carries the host data on `wb_dat_o`. A cycle started with only output enable (`host_oe_n` = 0) has `wb_we_o` = 0.
- R6: The rising edge that samples `wb_ack_i` = 1 during a cycle ends it, so strobe and cycle are 0 after that edge. They stay 0 while chip select remains low, until chip select has been released and applied again.
- R7: On the acknowledge of a read cycle, `wb_dat_i` is captured. From then on, the bridge drives that value onto `host_data` while `host_cs_n` and `host_oe_n` are both 0.
- R8: The acknowledge of a write cycle has no effect on the held read value. The next read shows the previous read data on `host_data` before its own acknowledge.
- R9: If chip select is released before any acknowledge, the cycle is abandoned: strobe is 0 after the third rising edge following the release, and 1 after the first two.
- R10: While `host_oe_n` is 1, the bridge does not drive `host_data`, so the value the host drives passes unchanged to `wb_dat_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Wishbone bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 12 | Host word address |
| host_data | inout | 16 | Shared host data bus |
| host_cs_n | input | 1 | Host chip select, active low |
| host_oe_n | input | 1 | Host read strobe (output enable), active low |
| host_we_n | input | 1 | Host write strobe, active low |
| wb_adr_o | output | 13 | Wishbone byte address |
| wb_dat_o | output | 16 | Wishbone write data |
| wb_dat_i | input | 16 | Wishbone read data |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
Host inputs change on a falling edge. Strobe is therefore sampled at the falling edges after the second and third rising edges, expecting 0 and then 1. The release of chip select in the abort case is checked with the same three-edge count. The acknowledge is given by the bench slave at the falling edge where strobe is first seen. The captured read data and the dropped strobe are checked at the next falling edge, one rising edge later. The returned host data is read combinationally at that point, because the pin driver has no register of its own.

// File: rtl/hb_bridge_pkg.sv
// Shared types for the host bus to Wishbone bridge.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package hb_bridge_pkg;

    // Cycle controller states.
    typedef enum logic [1:0] {
        HB_IDLE = 2'd0,   // waiting for chip select plus a strobe
        HB_BUS  = 2'd1,   // Wishbone cycle in progress
        HB_HOLD = 2'd2    // cycle done, waiting for chip select release
    } hb_state_e;

endpackage

// File: rtl/hb_sync.sv
// Multi-stage flop chain that brings asynchronous host signals into clk.
// Assumes: multi-bit payload is held stable by the host for longer than
// the chain depth, so per-bit skew settles before it is used.
module hb_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            // One synchronizer stage; stage 0 takes the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n)      stg[i] <= RST_VAL;
                else if (i == 0) stg[i] <= d;
                else             stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_cycle_ctrl.sv
// Runs one Wishbone master cycle per chip-select assertion and holds the
// read data returned with the acknowledge.
// Assumes: inputs are already synchronous to clk and active high.
module hb_cycle_ctrl
    import hb_bridge_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,      // chip select active
    input  logic          rd_req,   // output enable active
    input  logic          wr_req,   // write strobe active
    input  logic          ack,
    input  logic [DW-1:0] rdata_in,
    output logic          bus_on,
    output logic          wr_q,
    output logic [DW-1:0] rd_hold
);
    hb_state_e state, state_nx;

    // Next-state selection for the cycle controller.
    always_comb begin
        state_nx = state;
        unique case (state)
            HB_IDLE: if (sel && (rd_req || wr_req)) state_nx = HB_BUS;
            HB_BUS:  if (!sel)                      state_nx = HB_IDLE;
                     else if (ack)                  state_nx = HB_HOLD;
            HB_HOLD: if (!sel)                      state_nx = HB_IDLE;
            default:                                state_nx = HB_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= HB_IDLE;
        else        state <= state_nx;
    end

    // Write flag is latched when a cycle starts; write strobe has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 wr_q <= 1'b0;
        else if (state == HB_IDLE && state_nx == HB_BUS) wr_q <= wr_req;
        else if (state_nx == HB_IDLE)               wr_q <= 1'b0;
    end

    // Read holding register, loaded only by the acknowledge of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  rd_hold <= '0;
        else if (state == HB_BUS && sel && ack && !wr_q) rd_hold <= rdata_in;
    end

    assign bus_on = (state == HB_BUS);
endmodule

// File: rtl/hostbus_wb_bridge.sv
// Top level: asynchronous host memory bus to Wishbone master.
// Assumes: host holds address and write data stable while chip select is
// low; a strobe never toggles without chip select being released between
// accesses; address decoding is done downstream.
module hostbus_wb_bridge #(
    parameter int HOST_AW     = 12,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2,
    localparam int WB_AW      = HOST_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    inout  wire  [DW-1:0]      host_data,
    input  logic               host_cs_n,
    input  logic               host_oe_n,
    input  logic               host_we_n,
    output logic [WB_AW-1:0]   wb_adr_o,
    output logic [DW-1:0]      wb_dat_o,
    input  logic [DW-1:0]      wb_dat_i,
    output logic               wb_stb_o,
    output logic               wb_cyc_o,
    output logic               wb_we_o,
    input  logic               wb_ack_i
);
    localparam int PW = HOST_AW + DW;

    logic [2:0]    ctl_n;
    logic [PW-1:0] payload;
    logic          rd_drive;
    logic          bus_on;
    logic [DW-1:0] rd_hold;

    // Control strobes, reset to inactive (high).
    hb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_cs_n, host_oe_n, host_we_n}),
        .q     (ctl_n)
    );

    // Address and write data, travelling alongside the strobes.
    hb_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_pay (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_addr, host_data}),
        .q     (payload)
    );

    hb_cycle_ctrl #(.DW(DW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (!ctl_n[2]),
        .rd_req   (!ctl_n[1]),
        .wr_req   (!ctl_n[0]),
        .ack      (wb_ack_i),
        .rdata_in (wb_dat_i),
        .bus_on   (bus_on),
        .wr_q     (wb_we_o),
        .rd_hold  (rd_hold)
    );

    // Word address to byte address.
    assign wb_adr_o = {payload[PW-1:DW], 1'b0};
    assign wb_dat_o = payload[DW-1:0];
    assign wb_stb_o = bus_on;
    assign wb_cyc_o = bus_on;

    // Host pins are driven only during a host read.
    assign rd_drive  = !host_cs_n && !host_oe_n;
    assign host_data = rd_drive ? rd_hold : {DW{1'bz}};
endmodule

// File: rtl/hb_bridge_chk.sv
// Protocol checker for hostbus_wb_bridge, attached by bind.
// Assumes: default parameters (two synchronizer stages).
module hb_bridge_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_cs_n,
    input logic          wb_stb_o,
    input logic          wb_cyc_o,
    input logic          wb_we_o,
    input logic          wb_ack_i,
    input logic [DW-1:0] rd_hold
);
    AST_STB_CYC_TIED: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o == wb_cyc_o);                                           // R4
    AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && wb_ack_i && !host_cs_n) |=> !wb_stb_o);             // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wb_stb_o) |=> !wb_stb_o);                                  // R6
    AST_START_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_stb_o) |-> !$past(host_cs_n, 2));                       // R3
    AST_WE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && $past(wb_stb_o)) |-> $stable(wb_we_o));             // R5
    AST_HOLD_ONLY_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wb_stb_o && wb_ack_i && !wb_we_o) |-> $stable(rd_hold));  // R8
endmodule

bind hostbus_wb_bridge hb_bridge_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_cs_n (host_cs_n),
    .wb_stb_o  (wb_stb_o),
    .wb_cyc_o  (wb_cyc_o),
    .wb_we_o   (wb_we_o),
    .wb_ack_i  (wb_ack_i),
    .rd_hold   (rd_hold)
);

// File: tb/hostbus_wb_bridge_test.sv
module hostbus_wb_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] host_addr = '0;
    wire  [15:0] host_data;
    logic [15:0] host_dq = '0;
    logic        host_dq_en = 1'b0;
    logic        host_cs_n = 1'b1;
    logic        host_oe_n = 1'b1;
    logic        host_we_n = 1'b1;
    logic [12:0] wb_adr_o;
    logic [15:0] wb_dat_o;
    logic [15:0] wb_dat_i = '0;
    logic        wb_stb_o, wb_cyc_o, wb_we_o;
    logic        wb_ack_i = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit ack_en = 1'b1;
    bit done = 1'b0;

    typedef struct {
        bit          we;
        logic [12:0] adr;
        logic [15:0] wdat;
        logic [15:0] rdat;
    } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    assign host_data = host_dq_en ? host_dq : 16'hzzzz;

    hostbus_wb_bridge uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_data(host_data),
        .host_cs_n(host_cs_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
        .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
        .wb_stb_o(wb_stb_o), .wb_cyc_o(wb_cyc_o), .wb_we_o(wb_we_o),
        .wb_ack_i(wb_ack_i)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: slave model that pops the expected cycle and acknowledges it.
    initial begin
        forever begin
            @(negedge clk);
            if (wb_ack_i) begin
                wb_ack_i = 1'b0;
            end else if (ack_en && wb_stb_o) begin
                if (exp_q.size() == 0) begin
                    check("R6 unexpected cycle", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check("R4 cyc equals stb", {31'd0, wb_cyc_o}, 1);
                    check("R2 address", {19'd0, wb_adr_o}, {19'd0, it.adr});
                    check("R5 write flag", {31'd0, wb_we_o}, {31'd0, it.we});
                    if (it.we) check("R10 write data", {16'd0, wb_dat_o}, {16'd0, it.wdat});
                    wb_dat_i = it.rdat;
                    wb_ack_i = 1'b1;
                end
            end
        end
    end

    // Driver: one host access, pushing the expected Wishbone cycle.
    task automatic host_access(input bit we, input logic [11:0] a, input logic [15:0] wd,
                               input logic [15:0] rd, input bit chk_pre,
                               input logic [15:0] pre);
        item_t it;
        @(negedge clk);
        it.we = we; it.adr = {a, 1'b0}; it.wdat = wd; it.rdat = rd;
        exp_q.push_back(it);
        host_addr = a;
        host_cs_n = 1'b0;
        if (we) begin host_we_n = 1'b0; host_dq = wd; host_dq_en = 1'b1; end
        else    host_oe_n = 1'b0;
        #1;
        if (chk_pre) check("R8 held read data before ack", {16'd0, host_data}, {16'd0, pre});
        @(negedge clk);
        @(negedge clk);
        check("R3 no strobe after two edges", {31'd0, wb_stb_o}, 0);
        @(negedge clk);
        check("R3 strobe after three edges", {31'd0, wb_stb_o}, 1);
        @(negedge clk);
        check("R6 strobe dropped after ack", {31'd0, wb_stb_o}, 0);
        if (!we) check("R7 read data on host bus", {16'd0, host_data}, {16'd0, rd});
        repeat (5) @(negedge clk);
        check("R6 no second cycle while selected", {31'd0, wb_stb_o}, 0);
        host_cs_n = 1'b1; host_oe_n = 1'b1; host_we_n = 1'b1; host_dq_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Chip select withdrawn before the slave answers.
    task automatic abort_read(input logic [11:0] a);
        ack_en = 1'b0;
        @(negedge clk);
        host_addr = a; host_cs_n = 1'b0; host_oe_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 strobe up before abort", {31'd0, wb_stb_o}, 1);
        host_cs_n = 1'b1; host_oe_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 strobe held two edges after release", {31'd0, wb_stb_o}, 1);
        @(negedge clk);
        check("R9 strobe gone after three edges", {31'd0, wb_stb_o}, 0);
        repeat (3) @(negedge clk);
        ack_en = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 stb in reset", {31'd0, wb_stb_o}, 0);
        check("R1 cyc in reset", {31'd0, wb_cyc_o}, 0);
        check("R1 we in reset", {31'd0, wb_we_o}, 0);
        check("R1 adr in reset", {19'd0, wb_adr_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        host_access(1'b0, 12'h000, 16'h0000, 16'h1234, 1'b1, 16'h0000); // R7 first read
        host_access(1'b0, 12'hFFF, 16'h0000, 16'hA5C3, 1'b1, 16'h1234); // R2 top address
        host_access(1'b1, 12'h555, 16'hBEEF, 16'hDEAD, 1'b0, 16'h0000); // R5 R10 write
        host_access(1'b0, 12'h2AA, 16'h0000, 16'h0F0F, 1'b1, 16'hA5C3); // R8 write ack ignored
        abort_read(12'h123);                                            // R9
        host_access(1'b0, 12'h800, 16'h0000, 16'h8001, 1'b1, 16'h0F0F); // after abort
        host_access(1'b1, 12'h001, 16'h7E81, 16'h5555, 1'b0, 16'h0000); // R5 second write
        check("R6 all expected cycles seen", exp_q.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule